// File: doc/BRIEF.md
# Compressed Page Line Address Translator

This block sits in a memory controller and turns a request for one 64-byte line of a 4KB virtual page into the physical access needed for that line. The physical page is stored compressed at a single ratio for every line, so a line's data slot is found with one shift and one add. A line that did not fit its slot lives in an overflow area after the page's compressed data and its 64-byte metadata block. A line or page flagged as all zeros needs no memory access at all.

Each request carries the line index, the physical page base, a two-bit size class and the per-line flags taken from the page metadata: zero line, overflow, and overflow slot. It also carries the page-level zero flag. One cycle later the block returns the byte address and length to access, a skip flag for zero data, an overflow indication and the address of the page's metadata block. An optional wide-fetch request widens a compressed line access to the whole aligned 64-byte burst holding it, so neighbouring slots arrive in a single transfer.

Top module: `lcp_xlate`

## Requirements
- R1: A response appears exactly one clock after a request: `rsp_valid` is high in the cycle after `req_valid` was sampled high, and low otherwise.
- R2: Size class encoding is 0 = 4KB page with 64-byte slots, 1 = 2KB page with 32-byte slots, 2 = 1KB page with 16-byte slots, 3 = 512B page with 8-byte slots. An ordinary line gives `rsp_addr` = base + line × slot size and `rsp_len` = slot size.
- R3: Class 0 pages are uncompressed: the zero-line, overflow and wide-fetch inputs have no effect and the access is base + line × 64 with length 64.
- R4: On a compressed page, an overflow line gives `rsp_addr` = base + data size + 64 + slot × 64, where data size is 4096 >> class, with `rsp_len` = 64 and `rsp_exc` = 1.
- R5: On a compressed page, a zero line gives `rsp_skip` = 1, `rsp_len` = 0 and `rsp_addr` = 0.
- R6: A zero page gives `rsp_skip` = 1, `rsp_len` = 0, `rsp_addr` = 0 and `rsp_meta_addr` = 0 for every class and regardless of the line flags.
- R7: The zero-line flag takes priority over the overflow flag; `rsp_exc` is 0 for a skipped line.
- R8: With `req_wide` set on an ordinary compressed line, `rsp_addr` is the line address rounded down to a multiple of 64 and `rsp_len` = 64; it does not alter overflow or zero results.
- R9: For a compressed page that is not a zero page, `rsp_meta_addr` = base + (4096 >> class); for class 0 it is 0.
- R10: During and just after reset all response outputs are 0.
- R11: In a cycle following no request, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_line | input | 6 | Line index within the page |
| req_base | input | 40 | Physical page base address |
| req_cls | input | 2 | Page size class (see R2) |
| req_page_zero | input | 1 | Whole page is zero |
| req_line_zero | input | 1 | Line is zero (metadata) |
| req_exc | input | 1 | Line is stored in the overflow area |
| req_exc_slot | input | 6 | Overflow slot index |
| req_wide | input | 1 | Fetch the whole aligned 64-byte burst |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 40 | Physical byte address to access |
| rsp_len | output | 7 | Access length in bytes |
| rsp_skip | output | 1 | No memory access needed |
| rsp_exc | output | 1 | Access targets the overflow area |
| rsp_meta_addr | output | 40 | Address of the page metadata block |

## Verification
All state is the one response register, so any fault in the decode shows on the very next cycle as a wrong address, length or flag for that request. A wrong class decode moves every address on the page by a slot multiple and changes the length, so lines near the top of the page (index 63) expose it most strongly. A wrong priority between zero, overflow and wide fetch turns a skipped access into a real one or sends it to the wrong region, and the bench combines those flags deliberately to surface it. A stuck valid or a response not cleared on idle cycles appears in the cycle after an idle input.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

    typedef enum logic [1:0] {
        CLS_FULL  = 2'd0,
        CLS_HALF  = 2'd1,
        CLS_QUART = 2'd2,
        CLS_EIGHT = 2'd3
    } page_cls_e;

    typedef enum logic [1:0] {
        KIND_SKIP = 2'd0,
        KIND_EXC  = 2'd1,
        KIND_WIDE = 2'd2,
        KIND_SLOT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/lcp_class_decode.sv
module lcp_class_decode
    import lcp_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 64,
    parameter int OFFW       = 14,
    localparam int LOG2_LB   = $clog2(LINE_BYTES),
    localparam int SHW       = $clog2(LOG2_LB + 1),
    localparam int PAGE_B    = LINE_BYTES * LINES
) (
    input  page_cls_e          cls,
    output logic [SHW-1:0]     slot_shift,
    output logic [OFFW-1:0]    data_size,
    output logic               compressed
);

    logic [OFFW-1:0] page_full;

    always_comb begin
        page_full  = OFFW'(PAGE_B);
        slot_shift = SHW'(LOG2_LB) - SHW'(cls);
        data_size  = page_full >> cls;
        compressed = (cls != CLS_FULL);
    end

    always_comb begin
        if (compressed) begin
            p_slot_small_r2: assert (slot_shift < SHW'(LOG2_LB));
        end
    end

endmodule

// File: rtl/lcp_offset_gen.sv
module lcp_offset_gen #(
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 64,
    parameter int EXC_SLOTS  = 64,
    parameter int OFFW       = 14,
    localparam int LOG2_LB   = $clog2(LINE_BYTES),
    localparam int SHW       = $clog2(LOG2_LB + 1),
    localparam int LW        = $clog2(LINES),
    localparam int EW        = $clog2(EXC_SLOTS)
) (
    input  logic [LW-1:0]    line,
    input  logic [SHW-1:0]   slot_shift,
    input  logic [OFFW-1:0]  data_size,
    input  logic [EW-1:0]    exc_slot,
    output logic [OFFW-1:0]  slot_off,
    output logic [OFFW-1:0]  wide_off,
    output logic [OFFW-1:0]  exc_off
);

    localparam logic [OFFW-1:0] BURST_MASK = ~OFFW'(LINE_BYTES - 1);

    logic [OFFW-1:0] line_ext;
    logic [OFFW-1:0] exc_ext;

    always_comb begin
        line_ext = OFFW'(line);
        exc_ext  = OFFW'(exc_slot);
        slot_off = line_ext << slot_shift;
        wide_off = slot_off & BURST_MASK;
        exc_off  = data_size + OFFW'(LINE_BYTES) + (exc_ext << LOG2_LB);
    end

    always_comb begin
        p_wide_below_r8: assert (wide_off <= slot_off);
    end

endmodule

// File: rtl/lcp_xlate.sv
module lcp_xlate
    import lcp_pkg::*;
#(
    parameter int PA_W       = 40,
    parameter int LINE_BYTES = 64,
    parameter int LINES      = 64,
    parameter int EXC_SLOTS  = 64,
    localparam int LOG2_LB   = $clog2(LINE_BYTES),
    localparam int SHW       = $clog2(LOG2_LB + 1),
    localparam int LW        = $clog2(LINES),
    localparam int EW        = $clog2(EXC_SLOTS),
    localparam int LENW      = LOG2_LB + 1,
    localparam int PAGE_B    = LINE_BYTES * LINES,
    localparam int OFFW      = $clog2(PAGE_B + LINE_BYTES * (EXC_SLOTS + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LW-1:0]     req_line,
    input  logic [PA_W-1:0]   req_base,
    input  logic [1:0]        req_cls,
    input  logic              req_page_zero,
    input  logic              req_line_zero,
    input  logic              req_exc,
    input  logic [EW-1:0]     req_exc_slot,
    input  logic              req_wide,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [LENW-1:0]   rsp_len,
    output logic              rsp_skip,
    output logic              rsp_exc,
    output logic [PA_W-1:0]   rsp_meta_addr
);

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        logic [LENW-1:0] len;
        logic            skip;
        logic            exc;
        logic [PA_W-1:0] meta;
    } rsp_t;

    page_cls_e       cls;
    logic [SHW-1:0]  slot_shift;
    logic [OFFW-1:0] data_size;
    logic            compressed;
    logic [OFFW-1:0] slot_off;
    logic [OFFW-1:0] wide_off;
    logic [OFFW-1:0] exc_off;
    acc_kind_e       kind;
    rsp_t            rsp_d;
    rsp_t            rsp_q;

    assign cls = page_cls_e'(req_cls);

    lcp_class_decode #(
        .LINE_BYTES (LINE_BYTES),
        .LINES      (LINES),
        .OFFW       (OFFW)
    ) u_cls (
        .cls        (cls),
        .slot_shift (slot_shift),
        .data_size  (data_size),
        .compressed (compressed)
    );

    lcp_offset_gen #(
        .LINE_BYTES (LINE_BYTES),
        .LINES      (LINES),
        .EXC_SLOTS  (EXC_SLOTS),
        .OFFW       (OFFW)
    ) u_off (
        .line       (req_line),
        .slot_shift (slot_shift),
        .data_size  (data_size),
        .exc_slot   (req_exc_slot),
        .slot_off   (slot_off),
        .wide_off   (wide_off),
        .exc_off    (exc_off)
    );

    // Priority: zero page, then zero line, then overflow, then wide, then slot.
    always_comb begin
        if (req_page_zero || (compressed && req_line_zero)) begin
            kind = KIND_SKIP;
        end else if (compressed && req_exc) begin
            kind = KIND_EXC;
        end else if (compressed && req_wide) begin
            kind = KIND_WIDE;
        end else begin
            kind = KIND_SLOT;
        end
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (compressed && !req_page_zero) begin
                rsp_d.meta = req_base + PA_W'(data_size);
            end
            unique case (kind)
                KIND_SKIP: begin
                    rsp_d.skip = 1'b1;
                end
                KIND_EXC: begin
                    rsp_d.exc  = 1'b1;
                    rsp_d.addr = req_base + PA_W'(exc_off);
                    rsp_d.len  = LENW'(LINE_BYTES);
                end
                KIND_WIDE: begin
                    rsp_d.addr = req_base + PA_W'(wide_off);
                    rsp_d.len  = LENW'(LINE_BYTES);
                end
                default: begin
                    rsp_d.addr = req_base + PA_W'(slot_off);
                    rsp_d.len  = LENW'(1) << slot_shift;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_addr      = rsp_q.addr;
    assign rsp_len       = rsp_q.len;
    assign rsp_skip      = rsp_q.skip;
    assign rsp_exc       = rsp_q.exc;
    assign rsp_meta_addr = rsp_q.meta;

    p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_addr == '0 && !rsp_skip && rsp_len == '0));

    p_len_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_skip) |-> ($countones(rsp_len) == 1));

    p_full_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cls == 2'd0 && !req_page_zero) |=>
        (rsp_len == LENW'(LINE_BYTES) && !rsp_skip && !rsp_exc));

    p_exc_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cls != 2'd0 && req_exc && !req_line_zero && !req_page_zero) |=>
        (rsp_exc && rsp_addr >= $past(req_base) + PA_W'(PAGE_B >> 3) + PA_W'(LINE_BYTES)));

    p_page_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_page_zero) |=> (rsp_skip && rsp_len == '0 && rsp_meta_addr == '0));

    p_zero_over_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_skip |-> !rsp_exc);

endmodule

// File: tb/lcp_xlate_bench.sv
`timescale 1ns/1ps
module lcp_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_line = '0;
    logic [39:0] req_base = '0;
    logic [1:0]  req_cls = '0;
    logic        req_page_zero = 1'b0;
    logic        req_line_zero = 1'b0;
    logic        req_exc = 1'b0;
    logic [5:0]  req_exc_slot = '0;
    logic        req_wide = 1'b0;
    logic        rsp_valid;
    logic [39:0] rsp_addr;
    logic [6:0]  rsp_len;
    logic        rsp_skip;
    logic        rsp_exc;
    logic [39:0] rsp_meta_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcp_xlate u_lcp_xlate (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_line (req_line),
        .req_base (req_base), .req_cls (req_cls), .req_page_zero (req_page_zero),
        .req_line_zero (req_line_zero), .req_exc (req_exc), .req_exc_slot (req_exc_slot),
        .req_wide (req_wide), .rsp_valid (rsp_valid), .rsp_addr (rsp_addr),
        .rsp_len (rsp_len), .rsp_skip (rsp_skip), .rsp_exc (rsp_exc),
        .rsp_meta_addr (rsp_meta_addr)
    );

    localparam logic [39:0] BASE_A = 40'h12_3456_7000;
    localparam logic [39:0] BASE_B = 40'h00_8000_0200;

    function automatic longint slot_of(input int c);
        case (c)
            0: return 64;
            1: return 32;
            2: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic longint dsize_of(input int c);
        case (c)
            0: return 4096;
            1: return 2048;
            2: return 1024;
            default: return 512;
        endcase
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, sample at the next fall.
    task automatic issue(input int cls, input int line, input logic [39:0] base,
                         input bit lz, input bit pz, input bit ex, input int slot,
                         input bit wide);
        req_valid = 1'b1; req_cls = 2'(cls); req_line = 6'(line); req_base = base;
        req_line_zero = lz; req_page_zero = pz; req_exc = ex;
        req_exc_slot = 6'(slot); req_wide = wide;
        @(negedge clk);
    endtask

    task automatic go_idle();
        req_valid = 1'b0; req_line = '0; req_base = '0; req_cls = '0;
        req_line_zero = 1'b0; req_page_zero = 1'b0; req_exc = 1'b0;
        req_exc_slot = '0; req_wide = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 valid in reset", rsp_valid, 0);
        chk("R10 addr in reset", rsp_addr, 0);
        chk("R10 len in reset", rsp_len, 0);
    endtask

    task automatic t_normal();
        for (int c = 0; c < 4; c++) begin
            issue(c, 63, BASE_A, 0, 0, 0, 0, 0);
            chk("R1 valid", rsp_valid, 1);
            chk("R2 addr line63", rsp_addr, BASE_A + 63 * slot_of(c));
            chk("R2 len", rsp_len, slot_of(c));
            chk("R9 meta", rsp_meta_addr, (c == 0) ? 0 : BASE_A + dsize_of(c));
        end
        issue(3, 5, BASE_B, 0, 0, 0, 0, 0);
        chk("R2 addr 512B page", rsp_addr, BASE_B + 40);
        chk("R9 meta 512B page", rsp_meta_addr, BASE_B + 512);
    endtask

    task automatic t_uncomp_bypass();
        issue(0, 9, BASE_A, 1, 0, 1, 7, 1);
        chk("R3 addr flags ignored", rsp_addr, BASE_A + 9 * 64);
        chk("R3 len", rsp_len, 64);
        chk("R3 skip", rsp_skip, 0);
        chk("R3 exc", rsp_exc, 0);
    endtask

    task automatic t_exception();
        issue(2, 11, BASE_A, 0, 0, 1, 3, 0);
        chk("R4 addr 1KB", rsp_addr, BASE_A + 1024 + 64 + 3 * 64);
        chk("R4 len", rsp_len, 64);
        chk("R4 exc flag", rsp_exc, 1);
        issue(3, 0, BASE_B, 0, 0, 1, 63, 1);
        chk("R4 addr 512B slot63 wide ignored", rsp_addr, BASE_B + 512 + 64 + 63 * 64);
        chk("R8 wide no effect on exc len", rsp_len, 64);
    endtask

    task automatic t_zero_line();
        issue(1, 20, BASE_A, 1, 0, 0, 0, 0);
        chk("R5 skip", rsp_skip, 1);
        chk("R5 len", rsp_len, 0);
        chk("R5 addr", rsp_addr, 0);
        chk("R9 meta on zero line", rsp_meta_addr, BASE_A + 2048);
        issue(2, 20, BASE_A, 1, 0, 1, 5, 0);
        chk("R7 zero beats exc skip", rsp_skip, 1);
        chk("R7 exc cleared", rsp_exc, 0);
    endtask

    task automatic t_page_zero();
        for (int c = 0; c < 4; c++) begin
            issue(c, 33, BASE_A, 0, 1, 1, 2, 1);
            chk("R6 skip", rsp_skip, 1);
            chk("R6 len", rsp_len, 0);
            chk("R6 addr", rsp_addr, 0);
            chk("R6 meta", rsp_meta_addr, 0);
            chk("R6 exc", rsp_exc, 0);
        end
    endtask

    task automatic t_wide();
        issue(2, 5, BASE_A, 0, 0, 0, 0, 1);
        chk("R8 addr 1KB line5", rsp_addr, BASE_A + 64);
        chk("R8 len", rsp_len, 64);
        issue(3, 13, BASE_B, 0, 0, 0, 0, 1);
        chk("R8 addr 512B line13", rsp_addr, BASE_B + 64);
        issue(1, 3, BASE_A, 0, 0, 0, 0, 1);
        chk("R8 addr 2KB line3", rsp_addr, BASE_A + 64);
        issue(2, 4, BASE_A, 0, 0, 0, 0, 1);
        chk("R8 aligned stays", rsp_addr, BASE_A + 64);
    endtask

    task automatic t_idle();
        go_idle();
        chk("R11 valid idle", rsp_valid, 0);
        chk("R11 addr idle", rsp_addr, 0);
        chk("R11 meta idle", rsp_meta_addr, 0);
        chk("R11 len idle", rsp_len, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_idle();
        t_uncomp_bypass();
        t_exception();
        t_zero_line();
        t_page_zero();
        t_wide();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule